// File: doc/BRIEF.md
# Downshift burst bus master sequencer

This block is the bus-side engine of an expansion-bus master that moves a block of 32-bit words to or from a slave using burst cycles. The local side hands it a start address, a word count and a direction. It then opens an address phase with a start strobe. During that phase it also announces that it is able to fall back to 16-bit operation. From then on it issues one transfer per bus clock for as long as the burst continues. Write data comes from the head of a local FIFO, and read words are pushed back to the local side.

At the close of each address phase the sequencer samples two slave signals: a burst acknowledge and a 16-bit-size indication. If both are present, it downshifts for the rest of that burst. Each word is then split into a low-half and a high-half transfer. The high half is copied onto the low byte lanes by the sequencer itself. Without an acknowledge, the transfer is completed as a single cycle and the next word opens a fresh address phase. A burst is never allowed to leave a 1024-byte row. The last transfer in a row drops the burst request, and the next row begins with a new address phase.

Top module: `burst_dn_master`

## Requirements
- R1: After reset `start_n`, `burst_n` and `master16_n` are high, `be_n` is 4'b1111, and `busy`, `done`, `wr_pop` and `rd_push` are low.
- R2: A request with a non-zero count, taken while idle, is followed in the next cycle by an address phase. An address phase is exactly one cycle with `start_n`, `master16_n` and `burst_n` low, `be_n` = 4'b0000, and `addr` holding the current word address.
- R3: When the burst acknowledge (`slv_burst_n` low) is sampled at the end of the address phase and the slave is 32 bits wide, each word completes in one cycle. There is no further address phase, and `addr` rises by 4 per word.
- R4: Bits [31:10] of `addr` never change while a burst continues. The last transfer at a word whose address bits [9:2] are all ones drives `burst_n` high. When words remain, the next cycle is a new address phase at the following row.
- R5: When `slv_burst_n` and `slv_ex16_n` are both sampled low at the end of the address phase, every word of that burst takes two cycles. The first is the low half at the word address with `be_n` = 4'b1100. The second is the high half at address+2 with `be_n` = 4'b0011, with write bits [31:16] driven on both `dout[15:0]` and `dout[31:16]`. Read halves are taken from `din[15:0]`.
- R6: When `slv_burst_n` is sampled high at the end of the address phase, the transfer is a single 32-bit cycle with `burst_n` high. The next word begins with a new address phase.
- R7: The final transfer of the request drives `burst_n` high. In the following cycle `done` is high for one cycle and `busy` is low.
- R8: For writes, `wr_pop` is high in exactly the cycle in which a word's last transfer completes. In 32-bit transfers `dout` equals `wr_data`.
- R9: For reads, `rd_push` is high one cycle after a word's last transfer, with `rd_data` holding the whole word. In 16-bit mode the low half comes from the first transfer.
- R10: `req_valid` has no effect while `busy` is high, and a request with count 0 is ignored (no address phase, no `done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 32 | Word-aligned start byte address |
| req_count | input | 16 | Number of 32-bit words |
| req_write | input | 1 | 1 = write to slave, 0 = read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse after the final transfer |
| wr_data | input | 32 | Head of local write FIFO |
| wr_pop | output | 1 | Advance local write FIFO |
| rd_data | output | 32 | Assembled read word |
| rd_push | output | 1 | `rd_data` valid |
| start_n | output | 1 | Start strobe, active low |
| burst_n | output | 1 | Master burst request, active low |
| master16_n | output | 1 | Downshift capability, active low during address phase |
| wr_en | output | 1 | Direction of the bus cycle, 1 = write |
| addr | output | 32 | Bus byte address |
| be_n | output | 4 | Byte enables, active low |
| dout | output | 32 | Write data to bus |
| din | input | 32 | Read data from bus |
| slv_burst_n | input | 1 | Slave burst acknowledge, active low |
| slv_ex16_n | input | 1 | Slave 16-bit size, active low |

## Verification
The address phase appears one cycle after the request is sampled. The slave signals are sampled at the edge that closes the address phase, and they shape the very next cycle: a low-half transfer, a full-word burst transfer or a single cycle. `wr_pop` rises in the same cycle as the completing transfer. `rd_push` and `done` follow one cycle after it. The bench builds the full per-cycle expectation for each request, including these one-cycle offsets. It then compares every output at each falling edge, so that every registered result is already settled and no input is changing.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_XFER  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
  import bdm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int ROW_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_write,
  input  logic              slv_burst_n,
  input  logic              slv_ex16_n,
  output seq_state_t        state,
  output logic [ADDR_W-1:2] word_addr,
  output logic              half,
  output logic              mode16,
  output logic              burst_on,
  output logic              dir,
  output logic              word_end,
  output logic              last_xfer,
  output logic              done
);
  localparam int ROW_LSB = $clog2(ROW_BYTES);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:2] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              half_q, half_d;
  logic              m16_q, m16_d;
  logic              bon_q, bon_d;
  logic              dir_q, dir_d;
  logic              done_q, done_d;
  logic              row_end, cnt_last;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = &{1'b0, req_addr[1:0]};
  assign row_end  = &addr_q[ROW_LSB-1:2];
  assign cnt_last = (cnt_q == CNT_W'(1));
  assign word_end = !m16_q || half_q;
  assign last_xfer = word_end && (cnt_last || row_end);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    m16_d   = m16_q;
    bon_d   = bon_q;
    dir_d   = dir_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && (req_count != '0)) begin
          state_d = ST_START;
          addr_d  = req_addr[ADDR_W-1:2];
          cnt_d   = req_count;
          dir_d   = req_write;
          half_d  = 1'b0;
          m16_d   = 1'b0;
          bon_d   = 1'b0;
        end
      end
      ST_START: begin
        state_d = ST_XFER;
        bon_d   = !slv_burst_n;
        m16_d   = !slv_burst_n && !slv_ex16_n;
        half_d  = 1'b0;
      end
      ST_XFER: begin
        if (!word_end) begin
          half_d = 1'b1;
        end else begin
          half_d = 1'b0;
          cnt_d  = cnt_q - CNT_W'(1);
          addr_d = addr_q + 1'b1;
          if (cnt_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (bon_q && !row_end) begin
            state_d = ST_XFER;
          end else begin
            state_d = ST_START;
            bon_d   = 1'b0;
            m16_d   = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      m16_q   <= 1'b0;
      bon_q   <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      m16_q   <= m16_d;
      bon_q   <= bon_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
    end
  end

  assign state     = state_q;
  assign word_addr = addr_q;
  assign half      = half_q;
  assign mode16    = m16_q;
  assign burst_on  = bon_q;
  assign dir       = dir_q;
  assign done      = done_q;
endmodule

// File: rtl/bdm_outdec.sv
module bdm_outdec
  import bdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  seq_state_t          state,
  input  logic [ADDR_W-1:2]   word_addr,
  input  logic                half,
  input  logic                mode16,
  input  logic                burst_on,
  input  logic                dir,
  input  logic                word_end,
  input  logic                last_xfer,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                start_n,
  output logic                burst_n,
  output logic                master16_n,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W/8-1:0] be_n,
  output logic [DATA_W-1:0]   dout,
  output logic                wr_pop
);
  localparam int HALF_W = DATA_W / 2;
  localparam int BE_W   = DATA_W / 8;
  localparam int HB     = BE_W / 2;

  logic in_start, in_xfer;
  assign in_start = (state == ST_START);
  assign in_xfer  = (state == ST_XFER);

  always_comb begin
    start_n    = !in_start;
    master16_n = !in_start;
    wr_en      = dir && (in_start || in_xfer);
    addr       = {word_addr, half, 1'b0};
    if (in_start)      burst_n = 1'b0;
    else if (in_xfer)  burst_n = !(burst_on && !last_xfer);
    else               burst_n = 1'b1;
    if (in_start)                be_n = '0;
    else if (in_xfer && !mode16) be_n = '0;
    else if (in_xfer && !half)   be_n = {{HB{1'b1}}, {HB{1'b0}}};
    else if (in_xfer)            be_n = {{HB{1'b0}}, {HB{1'b1}}};
    else                         be_n = '1;
    if (mode16 && half) dout = {wr_data[DATA_W-1:HALF_W], wr_data[DATA_W-1:HALF_W]};
    else                dout = wr_data;
    wr_pop = in_xfer && dir && word_end;
  end
endmodule

// File: rtl/bdm_rdpack.sv
module bdm_rdpack #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              mode16,
  input  logic              half,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_push
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] lo_q;
  logic [DATA_W-1:0] word_q;
  logic              push_q;
  logic              lo_en, word_en;

  assign lo_en   = cap_en && mode16 && !half;
  assign word_en = cap_en && (!mode16 || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      word_q <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= word_en;
      if (lo_en) lo_q <= din[HALF_W-1:0];
      if (word_en) begin
        if (mode16) word_q <= {din[HALF_W-1:0], lo_q};
        else        word_q <= din;
      end
    end
  end

  assign rd_data = word_q;
  assign rd_push = push_q;
endmodule

// File: rtl/burst_dn_master.sv
module burst_dn_master
  import bdm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int ROW_BYTES = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CNT_W-1:0]    req_count,
  input  logic                req_write,
  output logic                busy,
  output logic                done,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                wr_pop,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_push,
  output logic                start_n,
  output logic                burst_n,
  output logic                master16_n,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W/8-1:0] be_n,
  output logic [DATA_W-1:0]   dout,
  input  logic [DATA_W-1:0]   din,
  input  logic                slv_burst_n,
  input  logic                slv_ex16_n
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  seq_state_t        state;
  logic [ADDR_W-1:2] word_addr;
  logic              half, mode16, burst_on, dir, word_end, last_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bdm_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ROW_BYTES(ROW_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_count(req_count), .req_write(req_write), .slv_burst_n(slv_burst_n),
    .slv_ex16_n(slv_ex16_n), .state(state), .word_addr(word_addr), .half(half),
    .mode16(mode16), .burst_on(burst_on), .dir(dir), .word_end(word_end),
    .last_xfer(last_xfer), .done(done)
  );

  bdm_outdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_outdec (
    .state(state), .word_addr(word_addr), .half(half), .mode16(mode16),
    .burst_on(burst_on), .dir(dir), .word_end(word_end), .last_xfer(last_xfer),
    .wr_data(wr_data), .start_n(start_n), .burst_n(burst_n),
    .master16_n(master16_n), .wr_en(wr_en), .addr(addr), .be_n(be_n),
    .dout(dout), .wr_pop(wr_pop)
  );

  bdm_rdpack #(.DATA_W(DATA_W)) u_rdpack (
    .clk(clk), .rst_n(rst_int_n), .cap_en((state == ST_XFER) && !dir),
    .mode16(mode16), .half(half), .din(din), .rd_data(rd_data), .rd_push(rd_push)
  );

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bdm_checker.sv
module bdm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_n,
  input logic              burst_n,
  input logic              master16_n,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        be_n,
  input logic              busy,
  input logic              done,
  input logic              slv_burst_n,
  input logic              slv_ex16_n
);
  // R2: address phase shape
  a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |-> (!master16_n && !burst_n && be_n == 4'b0000 && busy));

  // R4: a held burst request keeps the row and never opens a new start
  a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!burst_n) |-> (start_n && addr[ADDR_W-1:10] == $past(addr[ADDR_W-1:10])));

  // R5: acknowledge plus 16-bit size gives a low-half transfer next
  a_r5_downshift: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!start_n && !slv_burst_n && !slv_ex16_n) |-> (be_n == 4'b1100));

  // R5: low half is followed by the high half two bytes up
  a_r5_half_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_n && be_n == 4'b1100) |-> (be_n == 4'b0011 && addr == $past(addr) + 2));

  // R6: no acknowledge gives a single cycle
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!start_n && slv_burst_n) |-> (burst_n && start_n));

  // R7: completion follows a transfer that dropped the burst request
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(burst_n && start_n && busy) && !busy));
endmodule

bind burst_dn_master bdm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .burst_n(burst_n),
  .master16_n(master16_n), .addr(addr), .be_n(be_n), .busy(busy), .done(done),
  .slv_burst_n(slv_burst_n), .slv_ex16_n(slv_ex16_n)
);

// File: tb/burst_dn_master_tb.sv
`timescale 1ns/1ps
module burst_dn_master_tb;
  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [15:0] req_count;
  logic        busy, done, wr_pop, rd_push;
  logic [31:0] wr_data, rd_data, addr, dout, din;
  logic        start_n, burst_n, master16_n, wr_en;
  logic [3:0]  be_n;
  logic        sl_ack, sl_x16;

  int ncmp = 0;
  int nerr = 0;

  typedef struct {
    logic sn, mn, bn;
    logic [3:0] be;
    logic [31:0] a, d, rd;
    logic pop, push, done, busy, wr;
    string tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] wmem [0:63];
  int          whead;
  bit          b_pend;
  logic [31:0] b_rd;

  burst_dn_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_count(req_count), .req_write(req_write), .busy(busy), .done(done),
    .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_push(rd_push),
    .start_n(start_n), .burst_n(burst_n), .master16_n(master16_n), .wr_en(wr_en),
    .addr(addr), .be_n(be_n), .dout(dout), .din(din),
    .slv_burst_n(!sl_ack), .slv_ex16_n(!sl_x16)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] mh(input logic [31:0] a);
    return a[15:0] * 16'd3 + 16'h1234;
  endfunction

  // slave data model: a 16-bit slave drives only the low lanes
  assign din = sl_x16 ? {16'hDEAD, mh(addr)} : {mh(addr + 32'd2), mh(addr)};
  assign wr_data = wmem[whead[5:0]];

  always @(posedge clk) if (rst_n && wr_pop) whead <= whead + 1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R7 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
    end
  endtask

  function automatic exp_t blank(input bit bz, input bit wr);
    exp_t e;
    e.sn = 1; e.mn = 1; e.bn = 1; e.be = 4'hF; e.a = 0; e.d = 0; e.rd = 0;
    e.pop = 0; e.push = 0; e.done = 0; e.busy = bz; e.wr = wr; e.tag = "R1";
    return e;
  endfunction

  task automatic add(input exp_t e0);
    exp_t e = e0;
    if (b_pend) begin e.push = 1; e.rd = b_rd; b_pend = 0; end
    q.push_back(e);
  endtask

  task automatic build(input logic [31:0] base, input int cnt, input bit wr,
                       input bit ack, input bit x16, input int wb);
    logic [31:0] a, w;
    bit need, inb, m16, last, rowend;
    exp_t e;
    q.delete(); a = base; need = 1; inb = 0; m16 = 0; b_pend = 0;
    for (int k = 0; k < cnt; k++) begin
      w = wmem[(wb + k) % 64];
      rowend = (a[9:2] == 8'hFF);
      last = (k == cnt - 1) || rowend;
      if (need) begin
        e = blank(1, wr); e.sn = 0; e.mn = 0; e.bn = 0; e.be = 4'h0; e.a = a; e.d = w;
        e.tag = "R2"; add(e);
        inb = ack; m16 = ack && x16;
      end
      if (m16) begin
        e = blank(1, wr); e.bn = 0; e.be = 4'b1100; e.a = a; e.d = w; e.tag = "R5"; add(e);
        e = blank(1, wr); e.bn = last; e.be = 4'b0011; e.a = a + 2; e.d = {w[31:16], w[31:16]};
        e.pop = wr; e.tag = (rowend && k != cnt - 1) ? "R4" : (last ? "R7" : "R5"); add(e);
        b_rd = {mh(a + 2), mh(a)};
      end else begin
        e = blank(1, wr); e.bn = !(inb && !last); e.be = 4'h0; e.a = a; e.d = w; e.pop = wr;
        e.tag = !inb ? "R6" : ((rowend && k != cnt - 1) ? "R4" : (last ? "R7" : "R3"));
        add(e);
        b_rd = x16 ? {16'hDEAD, mh(a)} : {mh(a + 2), mh(a)};
      end
      b_pend = !wr;
      need = !inb || rowend;
      a = a + 4;
    end
    e = blank(0, wr); e.done = 1; e.tag = "R7"; add(e);
  endtask

  task automatic compare(input exp_t e);
    chk(e.tag, "start_n", start_n, e.sn);
    chk(e.tag, "master16_n", master16_n, e.mn);
    chk(e.tag, "burst_n", burst_n, e.bn);
    chk(e.tag, "be_n", be_n, e.be);
    chk(e.tag, "busy", busy, e.busy);
    chk("R7", "done", done, e.done);
    chk("R8", "wr_pop", wr_pop, e.pop);
    chk("R9", "rd_push", rd_push, e.push);
    if (e.push) chk("R9", "rd_data", rd_data, e.rd);
    if (e.busy) begin
      chk(e.tag, "addr", addr, e.a);
      chk(e.tag, "wr_en", wr_en, e.wr);
      if (e.wr) chk(e.pop && e.be == 4'h0 ? "R8" : e.tag, "dout", dout, e.d);
    end
  endtask

  task automatic run(input logic [31:0] base, input int cnt, input bit wr,
                     input bit ack, input bit x16, input bit inject);
    sl_ack = ack; sl_x16 = x16;
    build(base, cnt, wr, ack, x16, whead);
    @(negedge clk);
    req_valid = 1; req_addr = base; req_count = 16'(cnt); req_write = wr;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].tag == "R2" && inject) q[i].tag = "R10";
      compare(q[i]);
      if (inject && i == 1) begin
        req_valid = 1; req_addr = 32'h0000_5000; req_count = 16'd7; req_write = !wr;
      end
      if (inject && i == 2) req_valid = 0;
      if (i < q.size() - 1) @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) wmem[i] = 32'h1357_9BDF ^ (i * 32'h0102_0408) ^ (i << 20);
    whead = 0;
    rst_n = 0; req_valid = 0; req_addr = 0; req_count = 0; req_write = 0;
    sl_ack = 0; sl_x16 = 0; b_pend = 0; b_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", "start_n", start_n, 1);
    chk("R1", "burst_n", burst_n, 1);
    chk("R1", "master16_n", master16_n, 1);
    chk("R1", "be_n", be_n, 4'hF);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "wr_pop", wr_pop, 0);
    chk("R1", "rd_push", rd_push, 0);

    run(32'h0000_1000, 4, 1, 1, 0, 0);   // R3 R8: 32-bit write burst
    run(32'h0000_2040, 3, 0, 1, 0, 0);   // R3 R9: 32-bit read burst
    run(32'h0000_03F8, 4, 1, 1, 0, 0);   // R4: row break mid request
    run(32'h0000_0100, 3, 1, 1, 1, 0);   // R5: downshifted write
    run(32'h0000_0A20, 2, 0, 1, 1, 0);   // R5 R9: downshifted read
    run(32'h0000_3000, 3, 1, 0, 0, 0);   // R6: no acknowledge
    run(32'h0000_07FC, 2, 0, 1, 1, 0);   // R4 R5: 16-bit across a row
    run(32'h0000_0400, 1, 1, 1, 0, 0);   // R7: single word
    run(32'h0000_4000, 4, 0, 1, 0, 1);   // R10: request while busy

    // R10: zero count is ignored
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_6000; req_count = 16'd0; req_write = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R10", "start_n", start_n, 1);
      chk("R10", "busy", busy, 0);
      chk("R10", "done", done, 0);
      @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule